// File: doc/BRIEF.md
# Parallel Conflict-Free Extrinsic Memory Router

This block sits between a group of soft-in soft-out decoders running in parallel and the banked RAM that holds their extrinsic values. A frame of `FRAME_LEN` values is divided into equal contiguous slices, one slice per decoder, each `SUB_LEN = FRAME_LEN / NUM_DEC` long. All decoders step through their slices in lockstep. On every request cycle, each decoder either writes one value or asks for one value. The block forms that decoder's logical index from the current step. In interleaved mode it replaces the index by its permuted image. It then fetches a bank number and an in-bank position for that index from a loadable table, and carries the data through a crossbar.

The bank and position are not cut from address bits. They come from a per-index table that an offline tool has filled so that every step is collision-free, both in natural order and in permuted order. The table holds the bank, position and permutation entries and is loaded one index at a time through a plain write port. Reads return after one cycle, each decoder on its own lane. If a table ever sends two decoders to the same bank in one cycle, the lower-numbered decoder gets the bank and a sticky flag is raised.

Top module: `exr_router`

## Requirements
- R1: While reset is held and on the first cycle after it, `rd_valid` and `collision` are 0.
- R2: With `req_perm` = 0, decoder j (0-based, lane j of the data buses) at step t uses logical index j*SUB_LEN + t.
- R3: With `req_perm` = 1, decoder j at step t uses the index held in the permutation entry of j*SUB_LEN + t.
- R4: A clock edge with `cfg_we` = 1 and `cfg_idx` < FRAME_LEN stores `cfg_bank`, `cfg_pos` and `cfg_perm` as the bank, position and permutation entries of index `cfg_idx`. Later requests use the new entries.
- R5: A request with `req_valid` = 1 and `req_write` = 1 stores each decoder's lane of `wr_data` in the bank and position that the table gives for its index. A later read of the same index returns that value.
- R6: A request with `req_valid` = 1 and `req_write` = 0 raises `rd_valid` on the next cycle, and lane j of `rd_data` then carries decoder j's value. `rd_valid` is 0 after any cycle without such a request.
- R7: When several decoders resolve to one bank in the same cycle, the lowest-numbered one is served. The writes of the others are discarded, and on a read every decoder aimed at that bank receives the value at the winner's position.
- R8: `collision` rises on the cycle after a request in which two decoders resolve to the same bank, and it stays 1 until reset.
- R9: Cycles with `req_valid` = 0 change no stored value and no output. Collision-free requests never raise `collision`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Table entry write enable |
| cfg_idx | input | IDX_W | Logical index of the entry being loaded |
| cfg_bank | input | BANK_W | Bank number for that index |
| cfg_pos | input | POS_W | Position inside the bank for that index |
| cfg_perm | input | IDX_W | Permuted image of that index |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = store, 0 = fetch |
| req_perm | input | 1 | 1 = interleaved indexing, 0 = natural indexing |
| req_step | input | POS_W | Step within each decoder's slice, 0 to SUB_LEN-1 |
| wr_data | input | NUM_DEC*DATA_W | Write values, lane j for decoder j |
| rd_valid | output | 1 | rd_data holds the answer to the previous cycle's fetch |
| rd_data | output | NUM_DEC*DATA_W | Read values, lane j for decoder j |
| collision | output | 1 | Sticky flag: a bank was claimed twice in one cycle |

## Verification
The table is loaded with a bank mapping built from a step-skewed diagonal and a transposing permutation, so every step is collision-free in both orders. A full frame is written in natural order and read back in both orders: natural reads show the slice-to-index arithmetic, and permuted reads show that the permutation entries are applied rather than the identity. A second frame is then written through the permutation and read in natural order, which separates store-side permutation from fetch-side permutation. Idle cycles carrying write data show that an unasserted request leaves storage alone. Finally, one table entry is rewritten to force two decoders onto a single bank, which exercises the winner rule, the discarded write and the sticky flag.

// File: rtl/exr_pkg.sv
package exr_pkg;

  // Logical index handled by a decoder at a given step of its slice.
  function automatic int unsigned lane_index(int unsigned dec, int unsigned step,
                                             int unsigned slice_len);
    return dec * slice_len + step;
  endfunction

  // Width helper that never returns zero.
  function automatic int unsigned safe_clog2(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/exr_map_table.sv
module exr_map_table #(
  parameter int FRAME_LEN = 30,
  parameter int NUM_DEC   = 5,
  parameter int IDX_W     = 5,
  parameter int BANK_W    = 3,
  parameter int POS_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [BANK_W-1:0] cfg_bank,
  input  logic [POS_W-1:0]  cfg_pos,
  input  logic [IDX_W-1:0]  cfg_perm,
  input  logic              use_perm,
  input  logic [IDX_W-1:0]  look_idx  [NUM_DEC],
  output logic [BANK_W-1:0] look_bank [NUM_DEC],
  output logic [POS_W-1:0]  look_pos  [NUM_DEC]
);

  logic [BANK_W-1:0] bank_tab [FRAME_LEN];
  logic [POS_W-1:0]  pos_tab  [FRAME_LEN];
  logic [IDX_W-1:0]  perm_tab [FRAME_LEN];

  logic cfg_hit;
  assign cfg_hit = cfg_we && (int'(cfg_idx) < FRAME_LEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < FRAME_LEN; i++) begin
        bank_tab[i] <= '0;
        pos_tab[i]  <= '0;
        perm_tab[i] <= '0;
      end
    end else if (cfg_hit) begin
      bank_tab[cfg_idx] <= cfg_bank;
      pos_tab[cfg_idx]  <= cfg_pos;
      perm_tab[cfg_idx] <= cfg_perm;
    end
  end

  for (genvar j = 0; j < NUM_DEC; j++) begin : g_look
    logic [IDX_W-1:0] eff_idx;
    always_comb begin
      eff_idx = look_idx[j];
      if (use_perm && (int'(look_idx[j]) < FRAME_LEN))
        eff_idx = perm_tab[look_idx[j]];
      if (int'(eff_idx) < FRAME_LEN) begin
        look_bank[j] = bank_tab[eff_idx];
        look_pos[j]  = pos_tab[eff_idx];
      end else begin
        look_bank[j] = '0;
        look_pos[j]  = '0;
      end
    end
  end

  // R4
  cfg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hit |=> (bank_tab[$past(cfg_idx)] == $past(cfg_bank)) &&
                (pos_tab[$past(cfg_idx)]  == $past(cfg_pos)));

endmodule

// File: rtl/exr_arbiter.sv
module exr_arbiter #(
  parameter int NUM_DEC = 5,
  parameter int BANK_W  = 3,
  parameter int DEC_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [BANK_W-1:0] lane_bank  [NUM_DEC],
  output logic              bank_hit   [NUM_DEC],
  output logic [DEC_W-1:0]  bank_owner [NUM_DEC],
  output logic [NUM_DEC-1:0] lane_lost,
  output logic              conflict
);

  // Per bank: lowest-numbered decoder aimed at it.
  for (genvar b = 0; b < NUM_DEC; b++) begin : g_bank
    always_comb begin
      bank_hit[b]   = 1'b0;
      bank_owner[b] = '0;
      for (int j = NUM_DEC - 1; j >= 0; j--) begin
        if (valid && (lane_bank[j] == BANK_W'(b))) begin
          bank_hit[b]   = 1'b1;
          bank_owner[b] = DEC_W'(j);
        end
      end
    end
  end

  // Per decoder: lost if a lower decoder targets the same bank.
  for (genvar j = 0; j < NUM_DEC; j++) begin : g_lane
    logic shadowed;
    always_comb begin
      shadowed = 1'b0;
      for (int i = 0; i < j; i++)
        if (lane_bank[i] == lane_bank[j]) shadowed = 1'b1;
    end
    assign lane_lost[j] = valid && shadowed;

    // R7
    lost_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_lost[j] && (int'(lane_bank[j]) < NUM_DEC)) |->
        (bank_hit[lane_bank[j]] && (int'(bank_owner[lane_bank[j]]) < j)));
  end

  assign conflict = |lane_lost;

  // Winners per bank, derived from the loss vector.
  for (genvar b = 0; b < NUM_DEC; b++) begin : g_win
    logic [NUM_DEC-1:0] win;
    for (genvar j = 0; j < NUM_DEC; j++) begin : g_w
      assign win[j] = valid && (lane_bank[j] == BANK_W'(b)) && !lane_lost[j];
    end
    // R7
    one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(win));
  end

endmodule

// File: rtl/exr_bank.sv
module exr_bank #(
  parameter int DEPTH  = 6,
  parameter int DATA_W = 8,
  parameter int POS_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [POS_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic addr_ok;
  assign addr_ok = int'(addr) < DEPTH;

  always_ff @(posedge clk) begin
    if (we && addr_ok) mem[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata <= '0;
    else if (re)   rdata <= addr_ok ? mem[addr] : '0;
  end

  // R5
  bank_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr_ok) |=> (mem[$past(addr)] == $past(wdata)));

endmodule

// File: rtl/exr_router.sv
module exr_router #(
  parameter  int FRAME_LEN = 30,
  parameter  int NUM_DEC   = 5,
  parameter  int DATA_W    = 8,
  localparam int SUB_LEN   = FRAME_LEN / NUM_DEC,
  localparam int IDX_W     = exr_pkg::safe_clog2(FRAME_LEN),
  localparam int BANK_W    = exr_pkg::safe_clog2(NUM_DEC),
  localparam int POS_W     = exr_pkg::safe_clog2(SUB_LEN),
  localparam int BUS_W     = NUM_DEC * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [BANK_W-1:0] cfg_bank,
  input  logic [POS_W-1:0]  cfg_pos,
  input  logic [IDX_W-1:0]  cfg_perm,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_perm,
  input  logic [POS_W-1:0]  req_step,
  input  logic [BUS_W-1:0]  wr_data,
  output logic              rd_valid,
  output logic [BUS_W-1:0]  rd_data,
  output logic              collision
);

  localparam int DEC_W = BANK_W;

  logic [IDX_W-1:0]   lane_idx   [NUM_DEC];
  logic [BANK_W-1:0]  lane_bank  [NUM_DEC];
  logic [POS_W-1:0]   lane_pos   [NUM_DEC];
  logic               bank_hit   [NUM_DEC];
  logic [DEC_W-1:0]   bank_owner [NUM_DEC];
  logic [DATA_W-1:0]  bank_rdata [NUM_DEC];
  logic [NUM_DEC-1:0] lane_lost;
  logic               conflict;
  logic               rd_req;
  logic               wr_req;
  logic [BANK_W-1:0]  ret_bank_q [NUM_DEC];
  logic               rd_valid_q;
  logic               collision_q;

  assign rd_req = req_valid && !req_write;
  assign wr_req = req_valid && req_write;

  for (genvar j = 0; j < NUM_DEC; j++) begin : g_idx
    assign lane_idx[j] = IDX_W'(exr_pkg::lane_index(j, int'(req_step), SUB_LEN));
  end

  exr_map_table #(
    .FRAME_LEN(FRAME_LEN), .NUM_DEC(NUM_DEC),
    .IDX_W(IDX_W), .BANK_W(BANK_W), .POS_W(POS_W)
  ) u_map (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_bank(cfg_bank),
    .cfg_pos(cfg_pos), .cfg_perm(cfg_perm),
    .use_perm(req_perm), .look_idx(lane_idx),
    .look_bank(lane_bank), .look_pos(lane_pos)
  );

  exr_arbiter #(
    .NUM_DEC(NUM_DEC), .BANK_W(BANK_W), .DEC_W(DEC_W)
  ) u_arb (
    .clk(clk), .rst_n(rst_n), .valid(req_valid),
    .lane_bank(lane_bank), .bank_hit(bank_hit), .bank_owner(bank_owner),
    .lane_lost(lane_lost), .conflict(conflict)
  );

  // Crossbar into the banks: each bank follows its owning decoder.
  for (genvar b = 0; b < NUM_DEC; b++) begin : g_bank
    logic [POS_W-1:0]  sel_pos;
    logic [DATA_W-1:0] sel_data;
    assign sel_pos  = lane_pos[bank_owner[b]];
    assign sel_data = wr_data[int'(bank_owner[b]) * DATA_W +: DATA_W];

    exr_bank #(.DEPTH(SUB_LEN), .DATA_W(DATA_W), .POS_W(POS_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .we(wr_req && bank_hit[b]),
      .re(rd_req && bank_hit[b]),
      .addr(sel_pos), .wdata(sel_data), .rdata(bank_rdata[b])
    );
  end

  // Return path: remember which bank each decoder read from.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < NUM_DEC; j++) ret_bank_q[j] <= '0;
      rd_valid_q  <= 1'b0;
      collision_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_req;
      if (rd_req)
        for (int j = 0; j < NUM_DEC; j++) ret_bank_q[j] <= lane_bank[j];
      if (req_valid && conflict) collision_q <= 1'b1;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int j = 0; j < NUM_DEC; j++) begin
      if (int'(ret_bank_q[j]) < NUM_DEC)
        rd_data[j*DATA_W +: DATA_W] = bank_rdata[ret_bank_q[j]];
    end
  end

  assign rd_valid  = rd_valid_q;
  assign collision = collision_q;

  // R6
  rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  // R6
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

  // R8
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    collision |=> collision);

  // R9
  clean_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!collision && !(req_valid && conflict)) |=> !collision);

endmodule

// File: tb/tb_exr_router.sv
module tb_exr_router;

  localparam int CLK_PERIOD = 10;
  localparam int L  = 30;
  localparam int ND = 5;
  localparam int W  = L / ND;
  localparam int DW = 8;
  localparam int BW = ND * DW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [4:0]    cfg_idx = '0;
  logic [2:0]    cfg_bank = '0;
  logic [2:0]    cfg_pos = '0;
  logic [4:0]    cfg_perm = '0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic          req_perm = 1'b0;
  logic [2:0]    req_step = '0;
  logic [BW-1:0] wr_data = '0;
  logic          rd_valid;
  logic [BW-1:0] rd_data;
  logic          collision;

  exr_router dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_bank(cfg_bank),
    .cfg_pos(cfg_pos), .cfg_perm(cfg_perm),
    .req_valid(req_valid), .req_write(req_write), .req_perm(req_perm),
    .req_step(req_step), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .collision(collision)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  logic [DW-1:0] mdl [L];
  logic [BW-1:0] exp_q [$];
  string         tag_q [$];

  // Mapping used by the bench: skewed diagonal banks, transposing permutation.
  function automatic int map_bank(int i); return (i / W + i % W) % ND; endfunction
  function automatic int map_pos(int i);  return i % W; endfunction
  function automatic int map_perm(int i); return (i % W) * ND + i / W; endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Monitor: pops the scoreboard as read beats appear.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected beat", 64'(rd_data), 64'd0);
      end else begin
        logic [BW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data == e, t, 64'(rd_data), 64'(e));
      end
    end
  end

  task automatic cfg_load(input int idx, input int bank, input int pos, input int perm);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 5'(idx); cfg_bank = 3'(bank);
    cfg_pos = 3'(pos); cfg_perm = 5'(perm);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n, input bit junk);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      req_write = junk;
      wr_data   = junk ? {ND{8'hEE}} : '0;
      if (k > 0) check(rd_valid == 1'b0, "R6 idle valid", 64'(rd_valid), 64'd0);
    end
  endtask

  function automatic int eff_of(input bit pm, input int j, input int step);
    int li;
    li = j * W + step;
    return pm ? map_perm(li) : li;
  endfunction

  task automatic issue_write(input bit pm, input int step, input logic [BW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_perm = pm;
    req_step = 3'(step); wr_data = d;
    for (int j = 0; j < ND; j++) mdl[eff_of(pm, j, step)] = d[j*DW +: DW];
  endtask

  task automatic issue_read_exp(input bit pm, input int step, input logic [BW-1:0] e,
                                input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_perm = pm;
    req_step = 3'(step); wr_data = '0;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic issue_read(input bit pm, input int step, input string tag);
    logic [BW-1:0] e;
    for (int j = 0; j < ND; j++) e[j*DW +: DW] = mdl[eff_of(pm, j, step)];
    issue_read_exp(pm, step, e, tag);
  endtask

  bit done = 1'b0;

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(rd_valid == 1'b0 && collision == 1'b0, "R1 in reset",
          64'({rd_valid, collision}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_valid == 1'b0 && collision == 1'b0, "R1 after reset",
          64'({rd_valid, collision}), 64'd0);

    // R4: load the collision-free table
    for (int i = 0; i < L; i++) cfg_load(i, map_bank(i), map_pos(i), map_perm(i));

    // R2 / R5: natural-order frame write, then natural read back
    for (int t = 0; t < W; t++) begin
      logic [BW-1:0] d;
      for (int j = 0; j < ND; j++) d[j*DW +: DW] = 8'(j * 37 + t * 11 + 3);
      issue_write(1'b0, t, d);
    end
    for (int t = 0; t < W; t++) issue_read(1'b0, t, "R2 natural read");
    idle(2, 1'b0);

    // R3: permuted-order read of the same frame
    for (int t = 0; t < W; t++) issue_read(1'b1, t, "R3 permuted read");
    idle(2, 1'b0);

    // R3 / R5: permuted-order write, natural read back
    for (int t = 0; t < W; t++) begin
      logic [BW-1:0] d;
      for (int j = 0; j < ND; j++) d[j*DW +: DW] = 8'((j * 53) ^ (t * 29) ^ 8'hA5);
      issue_write(1'b1, t, d);
    end
    for (int t = 0; t < W; t++) issue_read(1'b0, t, "R5 write-permuted read-natural");

    // R9: idle cycles carrying write data must not disturb storage
    idle(4, 1'b1);
    for (int t = 0; t < W; t++) issue_read(1'b1, t, "R9 storage after idle");
    idle(2, 1'b0);
    check(collision == 1'b0, "R9 no collision yet", 64'(collision), 64'd0);

    // R4 / R7: force decoder 1 step 0 onto decoder 0's bank and position
    cfg_load(W, map_bank(0), map_pos(0), map_perm(W));
    begin
      logic [BW-1:0] d;
      logic [BW-1:0] e;
      for (int j = 0; j < ND; j++) d[j*DW +: DW] = 8'(8'h40 + j);
      issue_write(1'b0, 0, d);
      // loser's write discarded: both lanes 0 and 1 see lane 0's value
      e = '0;
      e[0 +: DW]  = 8'h40;
      e[DW +: DW] = 8'h40;
      for (int j = 2; j < ND; j++) e[j*DW +: DW] = 8'(8'h40 + j);
      @(negedge clk);
      req_valid = 1'b0;
      // R8: flag raised one cycle after the colliding request
      check(collision == 1'b1, "R8 flag rises", 64'(collision), 64'd1);
      issue_read_exp(1'b0, 0, e, "R7 winner data on shared bank");
    end
    idle(5, 1'b0);
    check(collision == 1'b1, "R8 flag sticky", 64'(collision), 64'd1);

    idle(2, 1'b0);
    check(exp_q.size() == 0, "R6 all beats returned", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule